// File: doc/BRIEF.md
# Majority-Stepped Triple-LFSR Keystream Generator

This block produces a pseudo-random keystream bit by bit from three linear feedback shift registers of different lengths. A start pulse captures a 64-bit key and a 22-bit frame number. The block clears its registers and shifts the 86 captured bits into all three registers together. It then runs a silent warm-up. Finally it delivers a fixed-length burst of keystream bits, one per clock, each marked by a valid strobe.

During warm-up and output the registers advance irregularly. Each register offers one clocking bit, the three bits are put to a majority vote, and only the registers that agree with the vote advance. Combining the keystream with data, and any framing around it, is left to the surrounding logic.

Top module: `ks_gen_top`

## Requirements
- R1: The three registers are 19, 22 and 23 bits long, with bit 0 as the least significant bit. When a register steps, it shifts left by one place, and the XOR of its feedback taps enters bit 0. The taps are bits 18, 17, 16 and 13 of the 19-bit register, bits 21 and 20 of the 22-bit register, and bits 22, 21, 20 and 7 of the 23-bit register.
- R2: On each majority step the clocking bits (bit 8, bit 10 and bit 10 of the 19-, 22- and 23-bit registers) are voted. Only the registers whose clocking bit equals the majority value step, so two or three registers step every time.
- R3: A `start` pulse seen while idle clears all three registers to zero and captures `key` and `frame`. Later changes on those inputs have no effect on the run.
- R4: Loading takes 86 cycles, and all three registers step in every one of them, regardless of the vote. In each loading step the current seed bit is XORed into the new bit 0 of every register. The seed bits are key bit 0 through key bit 63, then frame bit 0 through frame bit 21.
- R5: Loading is followed by 100 majority steps, during which `ks_valid` stays low.
- R6: Then 228 majority steps follow, and `ks_valid` is high in the 228 consecutive cycles after them. In each of those cycles `ks_bit` is the XOR of the three registers' top bits after that step. The first valid cycle is the 187th clock after the edge that accepted `start`.
- R7: `busy` is high from the edge that accepts `start` until the edge of the last output step. `busy` is already low in the cycle that presents the last keystream bit.
- R8: A `start` pulse while `busy` is high is ignored: the running sequence and its output are unaffected.
- R9: A synchronous `rst` returns the block to idle with `busy` and `ks_valid` low. It also clears the registers, so `ks_bit` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a run |
| key | input | 64 | Key, sampled when a run is accepted |
| frame | input | 22 | Frame number, sampled when a run is accepted |
| busy | output | 1 | High while loading, warming up or producing output |
| ks_bit | output | 1 | Keystream bit, meaningful when ks_valid is high |
| ks_valid | output | 1 | Marks a valid keystream bit |

## Verification
The embedded assertions check several properties on every cycle:
- Each register either performs an exact one-place shift or holds its value.
- Every majority step enables two or three registers.
- Every loading step enables all three.
- A start pulse during a run never drops busy early.
- Reset leaves the block idle.

Only the bench scenarios can show the rest. These include the correctness of the taps, of the seed order and of the vote outcome, seen in the full 228-bit output of several key and frame pairs checked against a reference model. The same holds for the exact latency to the first valid bit, the end of busy, and recovery after a mid-run reset.

// File: rtl/ks_gen_pkg.sv
package ks_gen_pkg;

   localparam int NREG = 3;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOAD = 2'd1,
      PH_WARM = 2'd2,
      PH_OUT  = 2'd3
   } phase_t;

   function automatic int len_of(input int idx);
      case (idx)
         0:       return 19;
         1:       return 22;
         default: return 23;
      endcase
   endfunction

   function automatic int unsigned tap_of(input int idx);
      case (idx)
         0:       return (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 16) | (32'd1 << 13);
         1:       return (32'd1 << 21) | (32'd1 << 20);
         default: return (32'd1 << 22) | (32'd1 << 21) | (32'd1 << 20) | (32'd1 << 7);
      endcase
   endfunction

   function automatic int ck_of(input int idx);
      case (idx)
         0:       return 8;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/ks_lfsr.sv
module ks_lfsr #(
   parameter int          LEN      = 19,
   parameter int unsigned TAP_MASK = 32'h0007_2000,
   parameter int          CKBIT    = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic step,
   input  logic din,
   output logic ck_bit,
   output logic msb
);

   localparam logic [LEN-1:0] TM = TAP_MASK[LEN-1:0];

   if (LEN < 2 || LEN > 32) begin : g_bad_len
      $error("ks_lfsr: LEN out of range");
   end
   if (CKBIT < 0 || CKBIT >= LEN) begin : g_bad_ck
      $error("ks_lfsr: CKBIT outside register");
   end
   if (TM[LEN-1] != 1'b1) begin : g_bad_tap
      $error("ks_lfsr: top bit must be a tap");
   end

   logic [LEN-1:0] q;
   logic           fb;

   assign fb     = ^(q & TM);
   assign ck_bit = q[CKBIT];
   assign msb    = q[LEN-1];

   always_ff @(posedge clk) begin
      if (rst || clr)
         q <= '0;
      else if (step)
         q <= {q[LEN-2:0], fb ^ din};
   end

   // R1: a step is an exact one-place left shift
   a_r1_shift: assert property (@(posedge clk) disable iff (rst)
      (step && !clr) |=> (q[LEN-1:1] == $past(q[LEN-2:0])));

   // R1: no step leaves the register untouched
   a_r1_hold: assert property (@(posedge clk) disable iff (rst)
      (!step && !clr) |=> $stable(q));

endmodule

// File: rtl/ks_vote.sv
module ks_vote #(
   parameter int N = 3
) (
   input  logic [N-1:0] ck,
   input  logic         force_all,
   output logic [N-1:0] en
);

   if (N % 2 == 0) begin : g_bad_n
      $error("ks_vote: N must be odd");
   end

   logic maj;

   if (N == 3) begin : g_three
      assign maj = (ck[0] & ck[1]) | (ck[0] & ck[2]) | (ck[1] & ck[2]);
   end else begin : g_count
      assign maj = ($countones(ck) > (N / 2));
   end

   for (genvar i = 0; i < N; i++) begin : g_en
      assign en[i] = force_all | (ck[i] == maj);
   end

endmodule

// File: rtl/ks_gen_top.sv
module ks_gen_top
   import ks_gen_pkg::*;
#(
   parameter int KEY_W  = 64,
   parameter int FRM_W  = 22,
   parameter int WARM_N = 100,
   parameter int OUT_N  = 228
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [KEY_W-1:0] key,
   input  logic [FRM_W-1:0] frame,
   output logic             busy,
   output logic             ks_bit,
   output logic             ks_valid
);

   localparam int SEED_W = KEY_W + FRM_W;
   localparam int MAX_A  = (SEED_W > WARM_N) ? SEED_W : WARM_N;
   localparam int MAX_N  = (MAX_A > OUT_N) ? MAX_A : OUT_N;
   localparam int CNT_W  = $clog2(MAX_N + 1);

   if (KEY_W < 1 || FRM_W < 1 || WARM_N < 1 || OUT_N < 1) begin : g_bad_cfg
      $error("ks_gen_top: all lengths must be at least 1");
   end

   phase_t             phase_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [SEED_W-1:0]  seed_q;
   logic               valid_q;
   logic               accept, clr, din, force_all, stepping, last_out;
   logic [NREG-1:0]    ck, msb, en, step;

   assign accept    = (phase_q == PH_IDLE) && start;
   assign clr       = accept;
   assign force_all = (phase_q == PH_LOAD);
   assign stepping  = (phase_q != PH_IDLE);
   assign din       = force_all & seed_q[0];
   assign step      = stepping ? en : '0;
   assign last_out  = (phase_q == PH_OUT) && (cnt_q == CNT_W'(OUT_N - 1));

   ks_vote #(.N(NREG)) u_vote (
      .ck        (ck),
      .force_all (force_all),
      .en        (en)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      ks_lfsr #(
         .LEN      (len_of(g)),
         .TAP_MASK (tap_of(g)),
         .CKBIT    (ck_of(g))
      ) u_lfsr (
         .clk    (clk),
         .rst    (rst),
         .clr    (clr),
         .step   (step[g]),
         .din    (din),
         .ck_bit (ck[g]),
         .msb    (msb[g])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         seed_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= (phase_q == PH_OUT);
         case (phase_q)
            PH_IDLE: if (start) begin
               phase_q <= PH_LOAD;
               cnt_q   <= '0;
               seed_q  <= {frame, key};
            end
            PH_LOAD: begin
               seed_q <= seed_q >> 1;
               if (cnt_q == CNT_W'(SEED_W - 1)) begin
                  phase_q <= PH_WARM;
                  cnt_q   <= '0;
               end else
                  cnt_q <= cnt_q + 1'b1;
            end
            PH_WARM: begin
               if (cnt_q == CNT_W'(WARM_N - 1)) begin
                  phase_q <= PH_OUT;
                  cnt_q   <= '0;
               end else
                  cnt_q <= cnt_q + 1'b1;
            end
            default: begin
               if (last_out) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
               end else
                  cnt_q <= cnt_q + 1'b1;
            end
         endcase
      end
   end

   assign busy     = (phase_q != PH_IDLE);
   assign ks_valid = valid_q;
   assign ks_bit   = ^msb;

   // R2: every majority step moves two or three registers
   a_r2_two_or_three: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_WARM || phase_q == PH_OUT) |-> ($countones(step) >= 2));

   // R4: every loading step moves all registers
   a_r4_load_all_step: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_LOAD) |-> (step == '1));

   // R8: a start during a run does not end it early
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
      (busy && start && !last_out) |=> busy);

   // R9: the cycle after reset is idle
   logic rst_d;
   always_ff @(posedge clk) rst_d <= rst;
   always_ff @(posedge clk) begin
      if (rst_d) begin
         a_r9_reset_idle: assert (!busy && !ks_valid);
      end
   end

endmodule

// File: tb/ks_gen_top_tb.sv
module ks_gen_top_tb;

   localparam int OUT_N = 228;
   localparam int FIRST = 187;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [63:0] key = '0;
   logic [21:0] frame = '0;
   logic        busy, ks_bit, ks_valid;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   ks_gen_top u_dut (
      .clk(clk), .rst(rst), .start(start), .key(key), .frame(frame),
      .busy(busy), .ks_bit(ks_bit), .ks_valid(ks_valid)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [OUT_N-1:0] ref_ks(input logic [63:0] k, input logic [21:0] f);
      logic [18:0] a; logic [21:0] b; logic [22:0] c;
      logic [OUT_N-1:0] r;
      logic bit_in, fa, fb, fc, m;
      a = '0; b = '0; c = '0; r = '0;
      for (int i = 0; i < 86; i++) begin
         bit_in = (i < 64) ? k[i] : f[i-64];
         fa = a[18] ^ a[17] ^ a[16] ^ a[13];
         fb = b[21] ^ b[20];
         fc = c[22] ^ c[21] ^ c[20] ^ c[7];
         a = {a[17:0], fa ^ bit_in};
         b = {b[20:0], fb ^ bit_in};
         c = {c[21:0], fc ^ bit_in};
      end
      for (int i = 0; i < 100 + OUT_N; i++) begin
         m  = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
         fa = a[18] ^ a[17] ^ a[16] ^ a[13];
         fb = b[21] ^ b[20];
         fc = c[22] ^ c[21] ^ c[20] ^ c[7];
         if (a[8] == m)  a = {a[17:0], fa};
         if (b[10] == m) b = {b[20:0], fb};
         if (c[10] == m) c = {c[21:0], fc};
         if (i >= 100) r[i-100] = a[18] ^ b[21] ^ c[22];
      end
      return r;
   endfunction

   // Full run: R1 R2 R3 R4 R5 R6 R7, optional stray start for R8
   task automatic run_case(input logic [63:0] k, input logic [21:0] f, input bit stray);
      logic [OUT_N-1:0] exp;
      int idx, first;
      exp = ref_ks(k, f);
      @(negedge clk);
      key = k; frame = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      key = ~k; frame = ~f;                       // R3: inputs no longer matter
      chk(busy == 1'b1, "R7 busy after start", busy, 1);
      idx = 0; first = -1;
      for (int n = 1; n <= 420; n++) begin
         start = stray && (n == 50 || n == 200);  // R8: ignored while busy
         @(negedge clk);
         if (ks_valid) begin
            if (first < 0) begin
               first = n;
               chk(n == FIRST, "R6 first valid cycle", n, FIRST);
            end
            if (idx < OUT_N) begin
               chk(ks_bit == exp[idx], stray ? "R8 keystream with stray start" : "R1 R2 R4 R6 keystream bit",
                   ks_bit, exp[idx]);
            end
            idx++;
         end
         if (n == FIRST - 1) chk(busy == 1'b1, "R5 busy in warm-up", busy, 1);
         if (n == FIRST + OUT_N - 1) chk(busy == 1'b0, "R7 busy low on last bit", busy, 0);
      end
      start = 1'b0;
      chk(idx == OUT_N, "R6 valid count", idx, OUT_N);
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R9 reset busy", busy, 0);
      chk(ks_valid == 1'b0, "R9 reset valid", ks_valid, 0);
      chk(ks_bit == 1'b0, "R9 reset keystream bit", ks_bit, 0);

      run_case(64'h0, 22'h0, 1'b0);
      run_case('1, '1, 1'b0);
      run_case(64'h1, 22'h0, 1'b0);
      run_case(64'h0, 22'h1, 1'b0);
      for (int i = 0; i < 3; i++) begin
         run_case({$urandom(), $urandom()}, 22'($urandom()), 1'b0);
      end
      run_case({$urandom(), $urandom()}, 22'($urandom()), 1'b1);

      // R9: mid-run reset
      @(negedge clk);
      key = 64'h0123_4567_89AB_CDEF; frame = 22'h2A5A5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (200) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(busy == 1'b0, "R9 busy after mid-run reset", busy, 0);
      chk(ks_valid == 1'b0, "R9 valid after mid-run reset", ks_valid, 0);
      chk(ks_bit == 1'b0, "R9 registers cleared", ks_bit, 0);
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R9 stays idle", busy, 0);
      run_case(64'hFEDC_BA98_7654_3210, 22'h15A5A, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule